// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight edge-triggered interrupt inputs, resolves them by fixed priority and presents a single request line to a processor. When the processor answers with an acknowledge strobe, the block returns an 8-bit vector: a programmable base plus the number of the winning input. It keeps three 8-bit registers: pending requests, inputs in service and an input mask. Software reaches them through two byte-wide addresses, a command address and a data address.

After reset the controller is unconfigured. A fixed command byte opens a three-word setup sequence on the data address: the vector base first, then a cascade word, then a mode word. Once that sequence is complete, data writes load the mask. Command bytes choose which status register a command-address read returns, and they retire in-service levels one at a time. The mode word can select automatic end of interrupt, so that an acknowledge leaves no level in service.

Two copies can be chained. A master marks, in its cascade word, the inputs that carry a slave. When the master grants such an input, it drives that input's number on a cascade ID output instead of returning a vector. A slave holds its own ID in its cascade word. It honours an acknowledge only when the cascade ID input matches that ID, so the slave's strobe is wired as the master's strobe delayed by one clock.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset the mask reads 0xFF, command-address reads return the request register, `rd_data`, `int_req`, `ack_valid` and `cas_drive` are 0, and an acknowledge has no effect until setup completes.
- R2: A command write of 0x11 clears the in-service register, selects the request register for reads and starts setup. The next three data writes are taken as vector base, cascade word and mode word. `int_req` stays low until the mode word is accepted.
- R3: An honoured acknowledge strobe in cycle t gives `ack_valid`=1 in cycle t+1, with `ack_vector` = (base + granted level) mod 256.
- R4: A rising edge on `irq_in[n]` sets request bit n. A grant of level n clears that bit. An input that stays high does not set the bit again.
- R5: Outside setup, a data write loads the mask and a data read (`addr_sel`=1) returns it. A masked input is still latched as a request but is never forwarded.
- R6: Priority is fixed: among unmasked pending requests, the lowest input number wins.
- R7: A request is forwarded only if its level is lower in number than every in-service bit. `int_req` shows the registers as they stood at the previous clock edge.
- R8: Command writes of 0x0B and 0x0A make later reads at `addr_sel`=0 return the in-service register and the request register respectively. `rd_data` is registered one cycle after `rd_en`.
- R9: A command write of 0x60+L, with L from 0 to 7, clears in-service bit L and no other bit.
- R10: When bit 1 of the mode word is 1 (automatic end of interrupt), an acknowledge sets no in-service bit.
- R11: An acknowledge that finds no forwardable request returns vector base+7 and leaves the in-service and request registers unchanged. This applies even when input 7 is masked.
- R12: In a master (`slave_sel`=0), granting a level whose cascade-word bit is 1 gives `cas_drive`=1, `cas_id_out` = the level and `ack_valid`=0 in the next cycle. The in-service bit is still set.
- R13: In a slave (`slave_sel`=1), an acknowledge is honoured only when `cas_id_in` equals bits 2:0 of the cascade word. Otherwise the registers and outputs stay unchanged. A slave never drives `cas_drive`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr_sel | input | 1 | 0 = command address, 1 = data address |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read byte, registered |
| irq_in | input | 8 | Interrupt inputs, rising-edge sensitive |
| int_req | output | 1 | Interrupt request to the processor |
| ack_strobe | input | 1 | One-cycle acknowledge |
| ack_valid | output | 1 | Vector valid, one cycle after the acknowledge |
| ack_vector | output | 8 | Returned vector |
| slave_sel | input | 1 | Role strap: 1 = slave, 0 = master |
| cas_id_in | input | 3 | Cascade ID seen by a slave |
| cas_id_out | output | 3 | Cascade ID driven by a master |
| cas_drive | output | 1 | Master is handing this acknowledge to a slave |

## Verification
The assertions assume that `ack_strobe` never falls in the same cycle as a command write. They also assume that `slave_sel` changes only with reset held. Without these assumptions, the end-of-interrupt and automatic end-of-interrupt properties could see a grant and a register update collide. The stimulus keeps every command, data write and acknowledge in cycles of its own, and it changes the role strap only inside a reset pulse. The interrupt inputs are held low through reset, so no edge is seen at reset release.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [2:0] {
    ST_UNCONF = 3'd0,
    ST_BASE   = 3'd1,
    ST_CASC   = 3'd2,
    ST_MODE   = 3'd3,
    ST_RUN    = 3'd4
  } setup_st_t;

  localparam logic [7:0] CMD_SETUP   = 8'h11;
  localparam logic [7:0] CMD_SHOW_IS = 8'h0B;
  localparam logic [7:0] CMD_SHOW_RQ = 8'h0A;
  localparam logic [7:0] CMD_EOI_0   = 8'h60;
  localparam int         AUTO_EOI_BIT = 1;

endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] irq_in,
  input  logic [N_IN-1:0] grant_clr,
  output logic [N_IN-1:0] req_q
);

  logic [N_IN-1:0] prev_q;

  for (genvar g = 0; g < N_IN; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[g] <= 1'b0;
        req_q[g]  <= 1'b0;
      end else begin
        prev_q[g] <= irq_in[g];
        // a fresh edge outranks a grant in the same cycle
        req_q[g]  <= (req_q[g] & ~grant_clr[g]) | (irq_in[g] & ~prev_q[g]);
      end
    end
  end

endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int N_IN  = 8,
  parameter int LVL_W = 3
) (
  input  logic [N_IN-1:0]  req,
  input  logic [N_IN-1:0]  mask,
  input  logic [N_IN-1:0]  insvc,
  output logic             fwd,
  output logic [LVL_W-1:0] fwd_lvl
);

  logic [N_IN-1:0]  cand;
  logic             cand_any;
  logic             svc_any;
  logic [LVL_W-1:0] svc_lvl;

  assign cand = req & ~mask;

  always_comb begin
    cand_any = 1'b0;
    fwd_lvl  = '0;
    svc_any  = 1'b0;
    svc_lvl  = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        cand_any = 1'b1;
        fwd_lvl  = LVL_W'(i);
      end
      if (insvc[i]) begin
        svc_any = 1'b1;
        svc_lvl = LVL_W'(i);
      end
    end
    fwd = cand_any && (!svc_any || (fwd_lvl < svc_lvl));
  end

endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import prio_irq_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int DW    = 8,
  parameter int LVL_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            addr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  input  logic [N_IN-1:0] req_q,
  input  logic [N_IN-1:0] isr_q,
  output logic            ready,
  output logic [DW-1:0]   vec_base,
  output logic [N_IN-1:0] casc_cfg,
  output logic            auto_eoi,
  output logic [N_IN-1:0] mask_q,
  output logic            setup_hit,
  output logic [N_IN-1:0] eoi_clr,
  output logic [DW-1:0]   rd_data
);

  localparam logic [DW-LVL_W-1:0] EOI_TAG = CMD_EOI_0[DW-1:LVL_W];

  setup_st_t st_q;
  logic      show_isr_q;
  logic      cmd_wr;
  logic      dat_wr;
  logic      eoi_hit;

  assign cmd_wr    = wr_en && !addr_sel;
  assign dat_wr    = wr_en && addr_sel;
  assign setup_hit = cmd_wr && (wr_data == CMD_SETUP);
  assign eoi_hit   = cmd_wr && (wr_data[DW-1:LVL_W] == EOI_TAG);
  assign ready     = (st_q == ST_RUN);

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      eoi_clr[i] = eoi_hit && (wr_data[LVL_W-1:0] == LVL_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_UNCONF;
      show_isr_q <= 1'b0;
      vec_base   <= '0;
      casc_cfg   <= '0;
      auto_eoi   <= 1'b0;
      mask_q     <= '1;
      rd_data    <= '0;
    end else begin
      if (setup_hit) begin
        st_q       <= ST_BASE;
        show_isr_q <= 1'b0;
      end else if (cmd_wr && wr_data == CMD_SHOW_IS) begin
        show_isr_q <= 1'b1;
      end else if (cmd_wr && wr_data == CMD_SHOW_RQ) begin
        show_isr_q <= 1'b0;
      end

      if (dat_wr) begin
        case (st_q)
          ST_BASE: begin
            vec_base <= wr_data;
            st_q     <= ST_CASC;
          end
          ST_CASC: begin
            casc_cfg <= N_IN'(wr_data);
            st_q     <= ST_MODE;
          end
          ST_MODE: begin
            auto_eoi <= wr_data[AUTO_EOI_BIT];
            st_q     <= ST_RUN;
          end
          default: mask_q <= N_IN'(wr_data);
        endcase
      end

      if (rd_en) begin
        if (addr_sel)        rd_data <= DW'(mask_q);
        else if (show_isr_q) rd_data <= DW'(isr_q);
        else                 rd_data <= DW'(req_q);
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N_IN = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          addr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [N_IN-1:0] irq_in,
  output logic          int_req,
  input  logic          ack_strobe,
  output logic          ack_valid,
  output logic [DW-1:0] ack_vector,
  input  logic          slave_sel,
  input  logic [$clog2(N_IN)-1:0] cas_id_in,
  output logic [$clog2(N_IN)-1:0] cas_id_out,
  output logic          cas_drive
);

  localparam int LVL_W = $clog2(N_IN);
  localparam logic [LVL_W-1:0] SPUR_LVL = LVL_W'(N_IN - 1);

  logic            ready_q;
  logic [DW-1:0]   vec_base;
  logic [N_IN-1:0] casc_cfg;
  logic            aeoi_q;
  logic [N_IN-1:0] imr_q;
  logic            setup_hit;
  logic [N_IN-1:0] eoi_clr;
  logic [N_IN-1:0] req_q;
  logic [N_IN-1:0] isr_q;
  logic            fwd;
  logic [LVL_W-1:0] fwd_lvl;
  logic            honor;
  logic [LVL_W-1:0] grant_lvl;
  logic [N_IN-1:0] grant_oh;
  logic            to_slave;

  pic_cmd_decode #(.N_IN(N_IN), .DW(DW), .LVL_W(LVL_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr_sel(addr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .req_q(req_q), .isr_q(isr_q),
    .ready(ready_q), .vec_base(vec_base), .casc_cfg(casc_cfg),
    .auto_eoi(aeoi_q), .mask_q(imr_q), .setup_hit(setup_hit),
    .eoi_clr(eoi_clr), .rd_data(rd_data)
  );

  pic_edge_latch #(.N_IN(N_IN)) u_req (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .grant_clr(grant_oh), .req_q(req_q)
  );

  pic_prio_resolve #(.N_IN(N_IN), .LVL_W(LVL_W)) u_prio (
    .req(req_q), .mask(imr_q), .insvc(isr_q),
    .fwd(fwd), .fwd_lvl(fwd_lvl)
  );

  assign honor     = ready_q && ack_strobe &&
                     (!slave_sel || (cas_id_in == casc_cfg[LVL_W-1:0]));
  assign grant_lvl = fwd ? fwd_lvl : SPUR_LVL;
  assign to_slave  = !slave_sel && fwd && casc_cfg[fwd_lvl];

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      grant_oh[i] = honor && fwd && (fwd_lvl == LVL_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q      <= '0;
      int_req    <= 1'b0;
      ack_valid  <= 1'b0;
      ack_vector <= '0;
      cas_drive  <= 1'b0;
      cas_id_out <= '0;
    end else begin
      if (setup_hit) isr_q <= '0;
      else           isr_q <= (isr_q & ~eoi_clr) | (aeoi_q ? '0 : grant_oh);
      int_req    <= ready_q && fwd;
      ack_valid  <= honor && !to_slave;
      ack_vector <= (honor && !to_slave) ? vec_base + DW'(grant_lvl) : '0;
      cas_drive  <= honor && to_slave;
      cas_id_out <= (honor && to_slave) ? grant_lvl : '0;
    end
  end

endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int N_IN  = 8,
  parameter int DW    = 8,
  parameter int LVL_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            addr_sel,
  input logic [DW-1:0]   wr_data,
  input logic            ack_strobe,
  input logic            slave_sel,
  input logic            int_req,
  input logic            ack_valid,
  input logic            cas_drive,
  input logic [N_IN-1:0] isr_q,
  input logic [N_IN-1:0] imr_q,
  input logic            aeoi_q,
  input logic            ready_q
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (imr_q == '1 && !int_req && !ack_valid && !cas_drive));

  // R2
  req_needs_setup_chk: assert property (@(posedge clk) disable iff (rst)
    int_req |-> $past(ready_q));

  // R3
  ack_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(ack_strobe));

  // R9
  eoi_clears_level_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !addr_sel && wr_data[DW-1:LVL_W] == 5'b01100 && !ack_strobe)
      |-> !isr_q[$past(wr_data[LVL_W-1:0])]);

  // R10
  auto_eoi_keeps_isr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ack_strobe && aeoi_q && !wr_en) |-> (isr_q == $past(isr_q)));

  // R12
  vector_or_cascade_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_valid, cas_drive}));

  // R13
  slave_never_drives_chk: assert property (@(posedge clk) disable iff (rst)
    cas_drive |-> !$past(slave_sel));

endmodule

bind prio_irq_ctrl prio_irq_chk #(.N_IN(N_IN), .DW(DW), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr_sel(addr_sel), .wr_data(wr_data),
  .ack_strobe(ack_strobe), .slave_sel(slave_sel), .int_req(int_req),
  .ack_valid(ack_valid), .cas_drive(cas_drive), .isr_q(isr_q), .imr_q(imr_q),
  .aeoi_q(aeoi_q), .ready_q(ready_q)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, addr_sel = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] irq_drv = 8'h00;
  logic       ack_strobe = 1'b0, slave_sel = 1'b0;
  logic [2:0] cas_id_in = 3'd0;
  logic [7:0] rd_data, ack_vector;
  logic       int_req, ack_valid, cas_drive;
  logic [2:0] cas_id_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr_sel(addr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq_in(irq_drv), .int_req(int_req),
    .ack_strobe(ack_strobe), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .slave_sel(slave_sel), .cas_id_in(cas_id_in), .cas_id_out(cas_id_out),
    .cas_drive(cas_drive)
  );

  // ---------------- behavioural reference model ----------------
  int         m_stage;
  bit [7:0]   m_irr, m_isr, m_imr, m_prev, m_base, m_casc;
  bit         m_aeoi, m_show_isr, armed;
  bit [7:0]   e_rd, e_vec;
  bit         e_int, e_av, e_cd;
  bit [2:0]   e_cid;

  function automatic int first_set(input bit [7:0] v);
    for (int k = 0; k < 8; k++) if (v[k]) return k;
    return 8;
  endfunction

  always @(posedge clk) begin
    armed = 1'b1;
    if (rst) begin
      m_stage = 0; m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_prev = 0;
      m_base = 0; m_casc = 0; m_aeoi = 0; m_show_isr = 0;
      e_rd = 0; e_vec = 0; e_int = 0; e_av = 0; e_cd = 0; e_cid = 0;
    end else begin
      int  top_req, top_svc, lvl;
      bit  can_fwd, hon, pass_on;
      bit [7:0] nirr, nisr;
      top_req = first_set(m_irr & ~m_imr);
      top_svc = first_set(m_isr);
      can_fwd = (top_req < 8) && (top_req < top_svc);
      e_int   = (m_stage == 4) && can_fwd;
      if (rd_en) e_rd = addr_sel ? m_imr : (m_show_isr ? m_isr : m_irr);
      hon     = (m_stage == 4) && ack_strobe &&
                (!slave_sel || cas_id_in == m_casc[2:0]);
      lvl     = can_fwd ? top_req : 7;
      pass_on = !slave_sel && can_fwd && m_casc[lvl];
      e_av    = hon && !pass_on;
      e_vec   = e_av ? 8'(m_base + 8'(lvl)) : 8'h00;
      e_cd    = hon && pass_on;
      e_cid   = e_cd ? 3'(lvl) : 3'd0;
      nirr = m_irr;
      if (hon && can_fwd) nirr[lvl] = 1'b0;
      nirr  = nirr | (irq_drv & ~m_prev);
      m_prev = irq_drv;
      nisr = m_isr;
      if (wr_en && !addr_sel && wr_data[7:3] == 5'b01100) nisr[wr_data[2:0]] = 1'b0;
      if (hon && can_fwd && !m_aeoi) nisr[lvl] = 1'b1;
      if (wr_en && !addr_sel) begin
        if (wr_data == 8'h11) begin m_stage = 1; nisr = 0; m_show_isr = 0; end
        else if (wr_data == 8'h0B) m_show_isr = 1;
        else if (wr_data == 8'h0A) m_show_isr = 0;
      end else if (wr_en && addr_sel) begin
        case (m_stage)
          1: begin m_base = wr_data; m_stage = 2; end
          2: begin m_casc = wr_data; m_stage = 3; end
          3: begin m_aeoi = wr_data[1]; m_stage = 4; end
          default: m_imr = wr_data;
        endcase
      end
      m_irr = nirr;
      m_isr = nisr;
    end
  end

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      check8(rd_data, e_rd, "R8 rd_data vs model");
      check8({7'd0, int_req}, {7'd0, e_int}, "R7 int_req vs model");
      check8({7'd0, ack_valid}, {7'd0, e_av}, "R3 ack_valid vs model");
      check8(ack_vector, e_vec, "R3 ack_vector vs model");
      check8({7'd0, cas_drive}, {7'd0, e_cd}, "R12 cas_drive vs model");
      check8({5'd0, cas_id_out}, {5'd0, e_cid}, "R12 cas_id_out vs model");
    end
  end

  // ---------------- stimulus tasks (entered at a falling edge) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic a, input logic [7:0] v);
    wr_en = 1'b1; addr_sel = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; addr_sel = 1'b0; wr_data = 8'h00;
  endtask

  task automatic get(input logic a, output logic [7:0] v);
    rd_en = 1'b1; addr_sel = a;
    @(negedge clk);
    rd_en = 1'b0; addr_sel = 1'b0;
    v = rd_data;
  endtask

  task automatic ack(output logic av, output logic [7:0] vec,
                     output logic cd, output logic [2:0] cid);
    ack_strobe = 1'b1;
    @(negedge clk);
    ack_strobe = 1'b0;
    av = ack_valid; vec = ack_vector; cd = cas_drive; cid = cas_id_out;
  endtask

  task automatic setup(input logic [7:0] base, input logic [7:0] casc, input logic [7:0] mode);
    put(1'b0, 8'h11);
    put(1'b1, base);
    put(1'b1, casc);
    put(1'b1, mode);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [7:0] v, vec;
    logic       av, cd;
    logic [2:0] cid;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state
    get(1'b1, v);  check8(v, 8'hFF, "R1 mask after reset");
    get(1'b0, v);  check8(v, 8'h00, "R1 request reg after reset");
    ack(av, vec, cd, cid); check8({7'd0, av}, 8'h00, "R1 ack ignored before setup");

    // R4 / R2: request latched before setup, but not forwarded
    irq_drv[0] = 1'b1; idle(2);
    check8({7'd0, int_req}, 8'h00, "R2 no int_req before setup");
    get(1'b0, v);  check8(v, 8'h01, "R4 edge sets request bit");

    setup(8'h20, 8'h04, 8'h01);
    put(1'b1, 8'h00);
    get(1'b1, v);  check8(v, 8'h00, "R5 mask readback");
    idle(2);
    check8({7'd0, int_req}, 8'h01, "R2 int_req after setup");
    ack(av, vec, cd, cid);
    check8(vec, 8'h20, "R3 vector base+0");
    put(1'b0, 8'h0B);
    get(1'b0, v);  check8(v, 8'h01, "R8 in-service readback");

    // R7 nesting, R6 priority
    irq_drv[3] = 1'b1; irq_drv[1] = 1'b1; idle(2);
    check8({7'd0, int_req}, 8'h00, "R7 blocked by level 0 in service");
    put(1'b0, 8'h60); idle(2);
    check8({7'd0, int_req}, 8'h01, "R9 int_req after EOI 0");
    ack(av, vec, cd, cid); check8(vec, 8'h21, "R6 level 1 beats level 3");
    idle(2);
    check8({7'd0, int_req}, 8'h00, "R7 level 3 below level 1");
    ack(av, vec, cd, cid);
    check8(vec, 8'h27, "R11 spurious vector");
    get(1'b0, v);  check8(v, 8'h02, "R11 in-service unchanged");
    put(1'b0, 8'h62);
    get(1'b0, v);  check8(v, 8'h02, "R9 EOI 2 leaves bit 1");
    put(1'b0, 8'h61); idle(2);
    ack(av, vec, cd, cid); check8(vec, 8'h23, "R6 level 3 after EOI 1");
    put(1'b0, 8'h63);
    irq_drv[1] = 1'b0; irq_drv[3] = 1'b0;

    // R5 masking, R11 spurious while masked
    put(1'b1, 8'h10);
    irq_drv[4] = 1'b1; idle(2);
    put(1'b0, 8'h0A);
    get(1'b0, v);  check8(v, 8'h10, "R4 level-held input not relatched");
    check8({7'd0, int_req}, 8'h00, "R5 masked input not forwarded");
    ack(av, vec, cd, cid); check8(vec, 8'h27, "R11 spurious with input masked");
    get(1'b0, v);  check8(v, 8'h10, "R11 request reg unchanged");
    put(1'b1, 8'h00); idle(2);
    ack(av, vec, cd, cid); check8(vec, 8'h24, "R5 unmasked level 4 granted");
    put(1'b0, 8'h64);
    irq_drv[4] = 1'b0;

    // R12 master cascade on input 2
    irq_drv[2] = 1'b1; idle(2);
    ack(av, vec, cd, cid);
    check8({6'd0, av, cd}, 8'h01, "R12 cascade handoff, no vector");
    check8({5'd0, cid}, 8'h02, "R12 cascade id");
    put(1'b0, 8'h0B);
    get(1'b0, v);  check8(v, 8'h04, "R12 in-service set on handoff");
    irq_drv[2] = 1'b0;

    // R2 setup clears in-service, R10 automatic EOI
    setup(8'h40, 8'h00, 8'h02);
    put(1'b0, 8'h0B);
    get(1'b0, v);  check8(v, 8'h00, "R2 setup clears in-service");
    irq_drv[5] = 1'b1; idle(2);
    ack(av, vec, cd, cid); check8(vec, 8'h45, "R10 vector in auto EOI");
    get(1'b0, v);  check8(v, 8'h00, "R10 no in-service bit");
    irq_drv = 8'h00;

    // R13 slave role
    rst = 1'b1; slave_sel = 1'b1; idle(2); rst = 1'b0; idle(1);
    get(1'b1, v);  check8(v, 8'hFF, "R1 mask after second reset");
    setup(8'h70, 8'h02, 8'h01);
    put(1'b1, 8'h00);
    irq_drv[6] = 1'b1; idle(2);
    cas_id_in = 3'd3;
    ack(av, vec, cd, cid); check8({6'd0, av, cd}, 8'h00, "R13 other id ignored");
    get(1'b0, v);  check8(v, 8'h40, "R13 request kept on mismatch");
    cas_id_in = 3'd2;
    ack(av, vec, cd, cid); check8(vec, 8'h76, "R13 matching id answered");
    idle(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule